// File: doc/BRIEF.md
# Tag-Matched Programmable Functional Unit

This block sits next to a processor register file and executes custom instructions whose meaning is not fixed by decode. It holds a small number of resident configurations. Each one pairs an 11-bit function number with an operation selector that picks one entry from a fixed menu of combinational operations. When an instruction issues, the requested function number is compared against every resident tag. On a match the operation is applied to the operands, and the result comes back in the same cycle. When nothing matches, the unit raises a configuration-miss flag instead. Service code then loads the missing configuration and replays the instruction.

The unit holds no data between operations, so a context switch needs no save or restore of operand or result state. Only the configuration table is registered. It is written one slot per cycle through a dedicated load port and is cleared by reset.

Top module: `pfu_dispatch`

## Requirements
- R1: With `iss_vld` high and `iss_fn` equal to the tag of a valid slot, `res_vld` is high and `res_miss` is low in that same cycle, and `res_data` carries that slot's operation on the current operands.
- R2: With `iss_vld` high and no valid slot whose tag equals `iss_fn`, `res_miss` is high, `res_vld` is low and `res_data` is zero in that same cycle.
- R3: With `iss_vld` low, `res_vld` and `res_miss` are both low and `res_data` is zero.
- R4: `res_vld` and `res_miss` are never high together, and every cycle with `iss_vld` high has exactly one of them high.
- R5: A synchronous reset (`rst_n` low at a clock edge) invalidates every slot, so every issue after reset misses until a load is done.
- R6: A load (`ld_en` high at a clock edge) writes the slot `ld_slot` with tag `ld_fn` and selector `ld_op` and marks it valid. The previous tag of that slot stops matching, and the other slots are unchanged.
- R7: A load becomes visible to issues from the cycle after its clock edge. An issue in the same cycle as a load sees the table as it was before the load.
- R8: When several valid slots hold the same tag, the slot with the lowest index supplies the operation.
- R9: Selector encodings are as follows. 0 gives a+b. 1 gives a-b. 2 gives a AND b. 3 gives a OR b. 4 gives a XOR b. 5 gives the number of ones in a. 6 gives a with its bits reversed. 7 gives a+b+c. 8 gives (a AND c) OR (b AND NOT c). Codes 9 to 15 give zero with `res_vld` still high. All arithmetic wraps modulo 2^DATA_W.
- R10: The result depends only on the current operands and the table contents, not on earlier issues. An instruction that missed returns the correct result when it is replayed after its configuration is loaded.
- R11: All 11 bits of the function number take part in the match. A request that differs from a tag only in bit 10 misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_vld | input | 1 | Custom instruction issued this cycle |
| iss_fn | input | 11 | Requested function number |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| opnd_c | input | 32 | Third operand |
| ld_en | input | 1 | Write a configuration slot at this edge |
| ld_slot | input | 2 | Slot index to write |
| ld_fn | input | 11 | Function number tag to store |
| ld_op | input | 4 | Operation selector to store |
| res_data | output | 32 | Operation result (zero unless hit) |
| res_vld | output | 1 | Hit: result valid this cycle |
| res_miss | output | 1 | Configuration-miss fault this cycle |

## Verification
The bench targets the following corner cases.
- Duplicate tags in two slots. A design that picks the wrong slot returns the other operation's result.
- Overwriting an occupied slot. A design that keeps the old tag matching keeps hitting where it should fault.
- A load in the same cycle as an issue. A bypassing or one-cycle-late table returns a hit or miss one cycle off.
- Tags that differ only in the top bit. A truncated compare falsely hits.
- Reset in the middle of a run, and replaying an instruction after a miss. A design that leaves stale slots valid, or keeps leftover state, reports the wrong flag or a wrong value.
- Every selector code, including the unused ones. This exposes swapped operand order or a wrong third-input path.

// File: rtl/pfu_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the programmable functional unit: operation
// selector encodings. Assumes a 4-bit selector field.
package pfu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_POPC = 4'd5,
        OP_BREV = 4'd6,
        OP_ADD3 = 4'd7,
        OP_BSEL = 4'd8
    } pfu_op_e;
endpackage

// File: rtl/pfu_cfg_store.sv
`timescale 1ns/1ps
// Resident configuration table: one valid bit, tag and selector per slot.
// Assumes one write per cycle; reset invalidates all slots synchronously.
module pfu_cfg_store #(
    parameter int SLOTS = 4,
    parameter int FN_W  = 11,
    parameter int SEL_W = 4,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [FN_W-1:0]                  wr_tag,
    input  logic [SEL_W-1:0]                 wr_sel,
    output logic [SLOTS-1:0]                 slot_vld,
    output logic [SLOTS-1:0][FN_W-1:0]       slot_tag,
    output logic [SLOTS-1:0][SEL_W-1:0]      slot_sel
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // Update one slot when it is the load target; clear valid on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_vld[s] <= 1'b0;
                slot_tag[s] <= '0;
                slot_sel[s] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(s))) begin
                slot_vld[s] <= 1'b1;
                slot_tag[s] <= wr_tag;
                slot_sel[s] <= wr_sel;
            end
        end
    end
endmodule

// File: rtl/pfu_tag_match.sv
`timescale 1ns/1ps
// Compares a requested function number against all resident tags and
// returns the selector of the lowest-index matching valid slot.
// Assumes the table is stable during the cycle (pure combinational).
module pfu_tag_match #(
    parameter int SLOTS = 4,
    parameter int FN_W  = 11,
    parameter int SEL_W = 4
) (
    input  logic [FN_W-1:0]             req_fn,
    input  logic [SLOTS-1:0]            slot_vld,
    input  logic [SLOTS-1:0][FN_W-1:0]  slot_tag,
    input  logic [SLOTS-1:0][SEL_W-1:0] slot_sel,
    output logic                        hit,
    output logic [SEL_W-1:0]            hit_sel
);
    logic [SLOTS-1:0] match_vec;

    for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
        assign match_vec[s] = slot_vld[s] && (slot_tag[s] == req_fn);
    end

    // Priority pick: scan from the top so the lowest index wins last.
    always_comb begin
        hit_sel = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (match_vec[s]) hit_sel = slot_sel[s];
        end
    end

    assign hit = |match_vec;
endmodule

// File: rtl/pfu_op_alu.sv
`timescale 1ns/1ps
// Fixed menu of combinational operations chosen by a selector.
// Unused selector codes give zero. Arithmetic wraps at DATA_W bits.
module pfu_op_alu
    import pfu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 4,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] c,
    output logic [DATA_W-1:0] y
);
    logic [CNT_W-1:0]  ones;
    logic [DATA_W-1:0] rev;

    // Count set bits of the first operand.
    always_comb begin
        ones = '0;
        for (int i = 0; i < DATA_W; i++) ones = ones + CNT_W'(a[i]);
    end

    // Mirror the first operand's bit order.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) rev[i] = a[DATA_W-1-i];
    end

    // Select the requested operation.
    always_comb begin
        case (sel)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_POPC: y = DATA_W'(ones);
            OP_BREV: y = rev;
            OP_ADD3: y = a + b + c;
            OP_BSEL: y = (a & c) | (b & ~c);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/pfu_dispatch.sv
`timescale 1ns/1ps
// Programmable functional unit: resolves a custom instruction's function
// number against resident configurations, returns the result the same
// cycle on a hit and raises a miss fault otherwise. Holds no data state.
module pfu_dispatch #(
    parameter int SLOTS  = 4,
    parameter int FN_W   = 11,
    parameter int SEL_W  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_vld,
    input  logic [FN_W-1:0]   iss_fn,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] opnd_c,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_slot,
    input  logic [FN_W-1:0]   ld_fn,
    input  logic [SEL_W-1:0]  ld_op,
    output logic [DATA_W-1:0] res_data,
    output logic              res_vld,
    output logic              res_miss
);
    logic [SLOTS-1:0]             slot_vld;
    logic [SLOTS-1:0][FN_W-1:0]   slot_tag;
    logic [SLOTS-1:0][SEL_W-1:0]  slot_sel;
    logic                         hit;
    logic [SEL_W-1:0]             hit_sel;
    logic [DATA_W-1:0]            alu_y;

    pfu_cfg_store #(.SLOTS(SLOTS), .FN_W(FN_W), .SEL_W(SEL_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ld_en), .wr_idx(ld_slot), .wr_tag(ld_fn), .wr_sel(ld_op),
        .slot_vld(slot_vld), .slot_tag(slot_tag), .slot_sel(slot_sel)
    );

    pfu_tag_match #(.SLOTS(SLOTS), .FN_W(FN_W), .SEL_W(SEL_W)) u_match (
        .req_fn(iss_fn), .slot_vld(slot_vld), .slot_tag(slot_tag),
        .slot_sel(slot_sel), .hit(hit), .hit_sel(hit_sel)
    );

    pfu_op_alu #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_alu (
        .sel(hit_sel), .a(opnd_a), .b(opnd_b), .c(opnd_c), .y(alu_y)
    );

    // Qualify the match with the issue strobe and gate the result.
    always_comb begin
        res_vld  = iss_vld && hit;
        res_miss = iss_vld && !hit;
        res_data = res_vld ? alu_y : '0;
    end
endmodule

// File: rtl/pfu_dispatch_chk.sv
`timescale 1ns/1ps
// Port-level property checker for pfu_dispatch, attached by bind.
module pfu_dispatch_chk #(
    parameter int FN_W   = 11,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_vld,
    input logic [FN_W-1:0]   iss_fn,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [DATA_W-1:0] opnd_c,
    input logic              ld_en,
    input logic [DATA_W-1:0] res_data,
    input logic              res_vld,
    input logic              res_miss
);
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_vld && res_miss)); // R4
    AST_ISSUE_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> $countones({res_vld, res_miss}) == 1); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_vld |-> (!res_vld && !res_miss && res_data == '0)); // R3
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |-> res_data == '0); // R2
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && iss_vld) |-> res_miss); // R5
    AST_NO_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && $past(iss_vld) && $past(rst_n) && !$past(ld_en) &&
         $stable(iss_fn) && $stable(opnd_a) && $stable(opnd_b) && $stable(opnd_c))
        |-> ($stable(res_data) && $stable(res_vld))); // R10
endmodule

bind pfu_dispatch pfu_dispatch_chk #(.FN_W(FN_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_fn(iss_fn),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c), .ld_en(ld_en),
    .res_data(res_data), .res_vld(res_vld), .res_miss(res_miss)
);

// File: tb/pfu_dispatch_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners plus seeded random load/issue mix
// against a bench-side table model.
module pfu_dispatch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        iss_vld;
    logic [10:0] iss_fn;
    logic [31:0] opnd_a, opnd_b, opnd_c;
    logic        ld_en;
    logic [1:0]  ld_slot;
    logic [10:0] ld_fn;
    logic [3:0]  ld_op;
    logic [31:0] res_data;
    logic        res_vld, res_miss;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    bit        m_v   [4];
    bit [10:0] m_tag [4];
    bit [3:0]  m_op  [4];

    always #2 clk = ~clk;

    pfu_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_fn(iss_fn),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .ld_en(ld_en), .ld_slot(ld_slot), .ld_fn(ld_fn), .ld_op(ld_op),
        .res_data(res_data), .res_vld(res_vld), .res_miss(res_miss)
    );

    function automatic bit [31:0] ref_op(bit [3:0] op, bit [31:0] a, bit [31:0] b, bit [31:0] c);
        bit [31:0] r;
        case (op)
            4'd0: r = a + b;
            4'd1: r = a - b;
            4'd2: r = a & b;
            4'd3: r = a | b;
            4'd4: r = a ^ b;
            4'd5: r = $countones(a);
            4'd6: begin
                for (int i = 0; i < 32; i++) r[31-i] = a[i];
            end
            4'd7: r = a + b + c;
            4'd8: r = (a & c) | (b & ~c);
            default: r = 32'd0;
        endcase
        return r;
    endfunction

    task automatic check(string req, bit ok, string what);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    task automatic clear_model();
        for (int s = 0; s < 4; s++) m_v[s] = 0;
    endtask

    // One cycle: drive at negedge, check outputs mid-cycle, then advance.
    task automatic step(string req, bit dl, bit [1:0] sl, bit [10:0] lf, bit [3:0] lo,
                        bit di, bit [10:0] f, bit [31:0] a, bit [31:0] b, bit [31:0] c);
        bit hit = 0;
        bit [3:0] op = 0;
        bit [31:0] ed;
        @(negedge clk);
        ld_en = dl; ld_slot = sl; ld_fn = lf; ld_op = lo;
        iss_vld = di; iss_fn = f; opnd_a = a; opnd_b = b; opnd_c = c;
        #1;
        for (int s = 3; s >= 0; s--)
            if (m_v[s] && m_tag[s] == f) begin hit = 1; op = m_op[s]; end
        ed = (di && hit) ? ref_op(op, a, b, c) : 32'd0;
        check(req, res_vld == (di && hit) && res_miss == (di && !hit) && res_data == ed,
              $sformatf("act vld=%0b miss=%0b data=%h exp vld=%0b miss=%0b data=%h",
                        res_vld, res_miss, res_data, di && hit, di && !hit, ed));
        @(posedge clk);
        if (dl) begin m_v[sl] = 1; m_tag[sl] = lf; m_op[sl] = lo; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; ld_en = 0; iss_vld = 0;
        @(posedge clk); @(negedge clk);
        rst_n = 1;
        clear_model();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: act timeout exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ld_en = 0; iss_vld = 0; iss_fn = 0; ld_slot = 0; ld_fn = 0; ld_op = 0;
        opnd_a = 0; opnd_b = 0; opnd_c = 0;
        clear_model();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R5: empty table after reset; R3 idle outputs.
        step("R5", 0, 0, 0, 0, 1, 11'h000, 1, 2, 3);
        step("R3", 0, 0, 0, 0, 0, 11'h000, 5, 6, 7);
        // R6/R1: load then hit.
        step("R6", 1, 0, 11'h123, 4'd0, 0, 0, 0, 0, 0);
        step("R1", 0, 0, 0, 0, 1, 11'h123, 32'hFFFF_FFFF, 32'd2, 0);
        // R11: differs only in the top bit.
        step("R11", 0, 0, 0, 0, 1, 11'h523, 1, 1, 0);
        // R8: duplicate tag in slot 2, slot 0 wins.
        step("R8", 1, 2, 11'h123, 4'd1, 0, 0, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 1, 11'h123, 10, 3, 0);
        // R6: replace slot 0; old tag now resolves to slot 2, new tag hits.
        step("R6", 1, 0, 11'h7FF, 4'd4, 0, 0, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 1, 11'h123, 10, 3, 0);
        step("R6", 0, 0, 0, 0, 1, 11'h7FF, 32'hF0F0, 32'h0FF0, 0);
        // R7: issue in same cycle as its load misses, then hits next cycle.
        step("R7", 1, 1, 11'h040, 4'd2, 1, 11'h040, 32'hFF, 32'h3C, 0);
        step("R7", 0, 0, 0, 0, 1, 11'h040, 32'hFF, 32'h3C, 0);
        // R9: every selector code through slot 3.
        for (int op = 0; op < 16; op++) begin
            step("R9", 1, 3, 11'h300, 4'(op), 0, 0, 0, 0, 0);
            step("R9", 0, 0, 0, 0, 1, 11'h300, 32'h8000_0013, 32'h1234_5678, 32'hFF00_FF00);
        end
        // R10: miss, load, replay.
        step("R10", 0, 0, 0, 0, 1, 11'h2AA, 7, 9, 11);
        step("R10", 1, 1, 11'h2AA, 4'd7, 0, 0, 0, 0, 0);
        step("R10", 0, 0, 0, 0, 1, 11'h2AA, 7, 9, 11);
        // R2/R4: random mix from a small tag pool.
        for (int i = 0; i < 600; i++) begin
            bit [10:0] pool [6] = '{11'h001, 11'h401, 11'h0AB, 11'h7FF, 11'h000, 11'h155};
            step("R2", $urandom % 4 == 0, 2'($urandom), pool[$urandom % 6], 4'($urandom % 16),
                 $urandom % 3 != 0, pool[$urandom % 6], $urandom, $urandom, $urandom);
        end
        // R5: reset mid-run empties all slots.
        do_reset();
        step("R5", 0, 0, 0, 0, 1, 11'h2AA, 1, 2, 3);
        step("R5", 0, 0, 0, 0, 1, 11'h7FF, 1, 2, 3);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial void'($urandom(32'd1357));
endmodule